// File: doc/BRIEF.md
# TDM Slave Channel Port

This block is the serial port of a slave device on a shared time-division-multiplexed line that a boot master controls. Each frame has `CHANNELS` timeslots of eight bits each. Channel k holds frame bit positions 8k to 8k+7, and every byte travels most significant bit first. The receive side runs on its own clock. It locks to an active-high frame sync and delivers only the byte of channel 0, as a byte with a one-cycle valid strobe.

The transmit side runs on a separate clock and sync. It drives the shared data line only during the one timeslot whose index equals the device's chip ID. The chip ID is captured from input pins while reset is held. In every other slot the output enable is low, so other slaves can use the line. Outgoing bytes enter through a valid/ready handshake into a single holding register. If no byte is waiting when the slot opens, the block sends all ones and reports an underrun.

The two sides keep different timing. The receive sync and data are both sampled on the rising clock edge, and the first data bit comes one whole cycle after the sync. The transmit sync is sampled on the rising edge, and data leaves on falling edges, starting half a cycle after the sync. Each side has two states in its state machine:

- Receive side, HUNT: waits for a sync. A sync moves it to RUN.
- Receive side, RUN: counts bits. A sync at the last bit position stays in RUN and restarts the frame. A sync anywhere else stays in RUN, restarts the frame and flags an error. Reaching the last bit with no sync returns it to HUNT.
- Transmit side, IDLE and RUN: the same transitions as the receive side.

Top module: `tdm_slave_port`

## Requirements
- R1: While reset is asserted, rx_valid, rx_frame_err, tx_oe, tx_sd, tx_underrun and tx_frame_err are 0, and tx_ready is 1.
- R2: rx_sync and rx_sd are sampled on rising rx_clk edges. Counting the edge that samples the sync as edge 0, channel k bit (7-i) is sampled on edge 8k+1+i, so bytes arrive MSB first.
- R3: Only channel 0 is delivered. rx_valid pulses for exactly one cycle after edge 8, with rx_byte holding the channel 0 byte. No other channel produces a valid.
- R4: A sync sampled on edge 8*CHANNELS, together with the last bit, starts the next frame with no framing error.
- R5: A receive sync on any other edge while a frame runs restarts the count from that edge and pulses rx_frame_err for one cycle. A partial channel 0 byte is dropped.
- R6: The chip ID is captured from chip_id while rst_n is low. Later changes on chip_id do not move the transmit slot.
- R7: tx_sync is sampled on rising tx_clk edges. Counting that edge as edge 0, frame bit j is driven on the falling edge that follows rising edge j.
- R8: tx_oe is 1 only for frame bits 8*ID to 8*ID+7, with the byte sent MSB first on tx_sd. When tx_oe is 0, tx_sd is 0.
- R9: tx_ready is 1 while the holding register is empty. A byte is taken on a rising edge with tx_valid and tx_ready both high, which drops tx_ready. Loading the byte at slot start empties the register again.
- R10: If the holding register is empty at slot start, the slot carries 0xFF and tx_underrun pulses for one cycle.
- R11: A transmit sync on an unexpected edge restarts the bit count and pulses tx_frame_err for one cycle.
- R12: If no sync arrives after the last bit of a transmit frame, tx_oe stays 0 until the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| chip_id | input | ID_W | Device identity pins, captured during reset |
| rx_clk | input | 1 | Receive bit clock |
| rx_sync | input | 1 | Receive frame sync, active high |
| rx_sd | input | 1 | Receive serial data |
| rx_byte | output | 8 | Channel 0 byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| rx_frame_err | output | 1 | Early receive sync pulse |
| tx_clk | input | 1 | Transmit bit clock |
| tx_sync | input | 1 | Transmit frame sync, active high |
| tx_byte | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | tx_byte is valid |
| tx_ready | output | 1 | Holding register empty |
| tx_sd | output | 1 | Transmit serial data |
| tx_oe | output | 1 | Drive enable for tx_sd |
| tx_underrun | output | 1 | Slot opened with no byte held |
| tx_frame_err | output | 1 | Early transmit sync pulse |

## Verification
A bit counter that is off by one shows up on the first byte. The valid strobe fires on the wrong edge, or the byte comes out shifted by one bit, and both are seen on edge 8 of the frame. A wrong latched ID, or a wrong slot comparison, moves the enable window by whole bytes within the same frame. A wrong holding-register flag shows up at the next slot start as a lost byte, a false underrun or a ready that stays low. A wrong state after an early sync shows up as a missing or extra framing-error pulse on that same edge.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    localparam int SLOT_BITS = 8;
    typedef logic [SLOT_BITS-1:0] slot_t;
    typedef enum logic {RX_HUNT = 1'b0, RX_RUN = 1'b1} rx_state_e;
    typedef enum logic {TX_IDLE = 1'b0, TX_RUN = 1'b1} tx_state_e;
endpackage

// File: rtl/tdm_rx.sv
module tdm_rx
    import tdm_pkg::*;
#(
    parameter int CHANNELS = 16,
    parameter int RX_CH    = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sync_i,
    input  logic  sd_i,
    output slot_t byte_o,
    output logic  valid_o,
    output logic  err_o
);
    localparam int FRAME_BITS = CHANNELS * SLOT_BITS;
    localparam int CW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] CH_FIRST = CW'(RX_CH * SLOT_BITS);
    localparam logic [CW-1:0] CH_LAST  = CW'(RX_CH * SLOT_BITS + SLOT_BITS - 1);

    rx_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic early;
    logic [SLOT_BITS-2:0] shift_q;
    slot_t byte_q;
    logic valid_q, err_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        early   = 1'b0;
        unique case (state_q)
            RX_HUNT: begin
                if (sync_i) begin
                    state_d = RX_RUN;
                    cnt_d   = '0;
                end
            end
            RX_RUN: begin
                if (sync_i) begin
                    cnt_d = '0;
                    early = (cnt_q != LAST_BIT);
                end else if (cnt_q == LAST_BIT) begin
                    state_d = RX_HUNT;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            byte_q  <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= early;
            if (state_q == RX_RUN && !early
                && cnt_q >= CH_FIRST && cnt_q <= CH_LAST) begin
                shift_q <= {shift_q[SLOT_BITS-3:0], sd_i};
                if (cnt_q == CH_LAST) begin
                    byte_q  <= {shift_q, sd_i};
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign byte_o  = byte_q;
    assign valid_o = valid_q;
    assign err_o   = err_q;
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
    import tdm_pkg::*;
#(
    parameter int CHANNELS = 16,
    parameter int ID_W     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] id_pins,
    input  logic            sync_i,
    input  slot_t           data_i,
    input  logic            valid_i,
    output logic            ready_o,
    output logic            sd_o,
    output logic            oe_o,
    output logic            underrun_o,
    output logic            err_o
);
    localparam int FRAME_BITS = CHANNELS * SLOT_BITS;
    localparam int CW = $clog2(FRAME_BITS);
    localparam int WW = CW + ID_W;
    localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);

    tx_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [ID_W-1:0] id_q;
    logic early, load, accept, in_slot;
    slot_t hold_q, byte_q;
    logic full_q, underrun_q, err_q, oe_q, sd_q;

    // identity pins are captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) id_q <= id_pins;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        early   = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (sync_i) begin
                    state_d = TX_RUN;
                    cnt_d   = '0;
                end
            end
            TX_RUN: begin
                if (sync_i) begin
                    cnt_d = '0;
                    early = (cnt_q != LAST_BIT);
                end else if (cnt_q == LAST_BIT) begin
                    state_d = TX_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    assign load    = (state_d == TX_RUN) && (cnt_d[2:0] == 3'd0)
                     && (WW'(cnt_d >> 3) == WW'(id_q));
    assign ready_o = !full_q;
    assign accept  = valid_i && !full_q;
    assign in_slot = (state_q == TX_RUN) && (WW'(cnt_q >> 3) == WW'(id_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= '0;
            byte_q     <= '1;
            full_q     <= 1'b0;
            underrun_q <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            err_q      <= early;
            underrun_q <= 1'b0;
            if (load) begin
                byte_q     <= full_q ? hold_q : '1;
                underrun_q <= !full_q;
            end
            if (accept) begin
                hold_q <= data_i;
                full_q <= 1'b1;
            end else if (load) begin
                full_q <= 1'b0;
            end
        end
    end

    // bits leave on the falling edge, half a cycle after the rising-edge count
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
            sd_q <= 1'b0;
        end else begin
            oe_q <= in_slot;
            sd_q <= in_slot ? byte_q[3'd7 - cnt_q[2:0]] : 1'b0;
        end
    end

    assign sd_o       = sd_q;
    assign oe_o       = oe_q;
    assign underrun_o = underrun_q;
    assign err_o      = err_q;
endmodule

// File: rtl/tdm_slave_port.sv
module tdm_slave_port #(
    parameter int CHANNELS = 16,
    parameter int ID_W     = 4
) (
    input  logic            rst_n,
    input  logic [ID_W-1:0] chip_id,
    input  logic            rx_clk,
    input  logic            rx_sync,
    input  logic            rx_sd,
    output logic [7:0]      rx_byte,
    output logic            rx_valid,
    output logic            rx_frame_err,
    input  logic            tx_clk,
    input  logic            tx_sync,
    input  logic [7:0]      tx_byte,
    input  logic            tx_valid,
    output logic            tx_ready,
    output logic            tx_sd,
    output logic            tx_oe,
    output logic            tx_underrun,
    output logic            tx_frame_err
);
    tdm_rx #(.CHANNELS(CHANNELS), .RX_CH(0)) u_rx (
        .clk     (rx_clk),
        .rst_n   (rst_n),
        .sync_i  (rx_sync),
        .sd_i    (rx_sd),
        .byte_o  (rx_byte),
        .valid_o (rx_valid),
        .err_o   (rx_frame_err)
    );

    tdm_tx #(.CHANNELS(CHANNELS), .ID_W(ID_W)) u_tx (
        .clk        (tx_clk),
        .rst_n      (rst_n),
        .id_pins    (chip_id),
        .sync_i     (tx_sync),
        .data_i     (tx_byte),
        .valid_i    (tx_valid),
        .ready_o    (tx_ready),
        .sd_o       (tx_sd),
        .oe_o       (tx_oe),
        .underrun_o (tx_underrun),
        .err_o      (tx_frame_err)
    );
endmodule

// File: rtl/tdm_slave_port_chk.sv
module tdm_slave_port_chk (
    input logic rst_n,
    input logic rx_clk,
    input logic rx_valid,
    input logic rx_frame_err,
    input logic tx_clk,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_sd,
    input logic tx_oe,
    input logic tx_underrun
);
    // R3: a delivered byte strobes for a single cycle
    p_valid_single_r3: assert property (@(posedge rx_clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5: an aborted frame never delivers a byte on the same edge
    p_err_no_valid_r5: assert property (@(posedge rx_clk) disable iff (!rst_n)
        rx_frame_err |-> !rx_valid);

    // R8: the line is quiet whenever the drive enable is low
    p_idle_low_r8: assert property (@(posedge tx_clk) disable iff (!rst_n)
        !tx_oe |-> !tx_sd);

    // R9: an accepted byte fills the holding register
    p_accept_fills_r9: assert property (@(posedge tx_clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R10: an underrun slot starts with a driven one
    p_underrun_ones_r10: assert property (@(posedge tx_clk) disable iff (!rst_n)
        tx_underrun |=> (tx_oe && tx_sd));
endmodule

bind tdm_slave_port tdm_slave_port_chk u_chk (
    .rst_n        (rst_n),
    .rx_clk       (rx_clk),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err),
    .tx_clk       (tx_clk),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_sd        (tx_sd),
    .tx_oe        (tx_oe),
    .tx_underrun  (tx_underrun)
);

// File: tb/tdm_slave_port_tb.sv
`timescale 1ns/1ps
module tdm_slave_port_tb;
    localparam int CH = 16;
    localparam int FB = CH * 8;
    localparam int ID = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] chip_id = 4'(ID);
    logic rx_sync = 1'b0, rx_sd = 1'b0;
    logic tx_sync = 1'b0, tx_valid = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic [7:0] rx_byte;
    logic rx_valid, rx_frame_err, tx_ready, tx_sd, tx_oe, tx_underrun, tx_frame_err;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tdm_slave_port #(.CHANNELS(CH), .ID_W(4)) u_dut (
        .rst_n(rst_n), .chip_id(chip_id),
        .rx_clk(clk), .rx_sync(rx_sync), .rx_sd(rx_sd),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
        .tx_clk(clk), .tx_sync(tx_sync), .tx_byte(tx_byte), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_sd(tx_sd), .tx_oe(tx_oe),
        .tx_underrun(tx_underrun), .tx_frame_err(tx_frame_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic test_reset();
        #35;
        chk(rx_valid == 0 && rx_frame_err == 0, "R1 rx outputs", {rx_valid, rx_frame_err}, 0);
        chk(tx_oe == 0 && tx_sd == 0 && tx_underrun == 0 && tx_frame_err == 0,
            "R1 tx outputs", {tx_oe, tx_sd, tx_underrun, tx_frame_err}, 0);
        chk(tx_ready == 1, "R1 tx_ready", tx_ready, 1);
        @(posedge clk); #5;
        rst_n = 1'b1;
        chip_id = 4'd5; // R6: pins change after reset
    endtask

    // R2 R3 R4 R5: sync on edge 0 and on edge s2, channel 0 bytes b1 and b2
    task automatic rx_seq(input int s2, input logic [7:0] b1, input logic [7:0] b2, input string tag);
        int nval = 0;
        int nerr = 0;
        int err_at = -1;
        int exp_val = (s2 > 8) ? 2 : 1;
        for (int e = 0; e <= s2 + FB + 2; e++) begin
            rx_sync = (e == 0) || (e == s2);
            if (e > s2 && e <= s2 + 8) rx_sd = b2[7 - (e - s2 - 1)];
            else if (e >= 1 && e <= 8) rx_sd = b1[8 - e];
            else rx_sd = ((e % 5) < 2);
            @(posedge clk); #5;
            if (rx_valid) nval++;
            if (rx_frame_err) begin nerr++; err_at = e; end
            if (e == 8 && s2 > 8)
                chk(rx_valid && rx_byte == b1, {tag, " R3 first byte"}, {rx_valid, rx_byte}, {1'b1, b1});
            if (e == s2 + 8)
                chk(rx_valid && rx_byte == b2, {tag, " R2 second byte"}, {rx_valid, rx_byte}, {1'b1, b2});
        end
        rx_sync = 1'b0;
        chk(nval == exp_val, {tag, " R3 valid count"}, nval, exp_val);
        if (s2 == FB) chk(nerr == 0, {tag, " R4 no error"}, nerr, 0);
        else chk(nerr == 1 && err_at == s2, {tag, " R5 error edge"}, err_at, s2);
    endtask

    // R7 R8 R9 R10 R11 R12: optional byte, sync on edge 0 and optionally s2
    task automatic tx_seq(input bit give, input logic [7:0] b, input int s2, input string tag);
        int base = (s2 > 0) ? s2 : 0;
        int ss = base + 8 * ID;
        logic [7:0] exp_b = give ? b : 8'hFF;
        logic [7:0] obs = 8'h00;
        int oe_in = 0;
        int bad_out = 0;
        int late_oe = 0;
        if (give) begin
            tx_valid = 1'b1; tx_byte = b;
            @(posedge clk); #5;
            tx_valid = 1'b0; tx_byte = 8'h00;
            chk(tx_ready == 0, {tag, " R9 ready drops"}, tx_ready, 0);
        end
        for (int e = 0; e <= base + FB + 3; e++) begin
            tx_sync = (e == 0) || (s2 > 0 && e == s2);
            @(posedge clk);
            @(negedge clk); #5;
            if (e >= ss && e < ss + 8) begin
                if (tx_oe) oe_in++;
                obs[7 - (e - ss)] = tx_sd;
            end else begin
                if (tx_oe || tx_sd) bad_out++;
                if (e >= base + FB && tx_oe) late_oe++;
            end
            if (e == ss) begin
                chk(tx_ready == 1, {tag, " R9 ready back"}, tx_ready, 1);
                chk(tx_underrun == !give, {tag, " R10 underrun"}, tx_underrun, !give);
            end
            if (s2 > 0 && e == s2)
                chk(tx_frame_err == 1, {tag, " R11 frame error"}, tx_frame_err, 1);
        end
        tx_sync = 1'b0;
        chk(obs == exp_b, {tag, " R7 R8 slot byte"}, obs, exp_b);
        chk(oe_in == 8, {tag, " R6 R8 enable window"}, oe_in, 8);
        chk(bad_out == 0, {tag, " R8 quiet outside slot"}, bad_out, 0);
        chk(late_oe == 0, {tag, " R12 stop without sync"}, late_oe, 0);
    endtask

    initial begin
        test_reset();
        repeat (3) @(posedge clk);
        #5;
        rx_seq(FB, 8'hA5, 8'h3C, "rx back-to-back");
        rx_seq(4,  8'h81, 8'h7E, "rx early in slot");
        rx_seq(60, 8'hC3, 8'h5A, "rx early later");
        tx_seq(1'b1, 8'hB4, 0,  "tx byte");
        tx_seq(1'b0, 8'h00, 0,  "tx underrun");
        tx_seq(1'b1, 8'h69, 10, "tx early sync");
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule